// File: doc/BRIEF.md
# One-Lane Tunnel Traffic Controller

This block runs the traffic lights at the two ends of a single-lane tunnel that links a mainland to an island. Cars may travel through the tunnel in only one direction at a time. Each end has a light controller that asks for the tunnel when a car waits at its stop line. It shows green while it holds the tunnel, and it hands the tunnel back once the cars it let in have all come out at the far end. A central arbiter gives the tunnel to one end at a time. Two occupancy counters track how many cars are inside the tunnel and how many are on the island.

The island can hold at most `ISLE_CAP` cars. The mainland end is therefore refused the tunnel while the island is full. An active mainland green also ends as soon as the cars on the island plus the cars already heading there reach that limit. When both ends are waiting, the grant alternates between them. Each grant lets at least one car through before the holder yields to a waiting opposite end, so neither end starves.

The entry sensors are levels: high while a car stands at that end's stop line, low once it has driven in. The exit sensors are one-cycle pulses: one car leaving the tunnel at that end. At most one exit pulse arrives per cycle.

Top module: `tunnel_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both lights go red, no end holds the tunnel and both counters return to zero.
- R2: An end's light turns green only while that end holds the grant. A request into an idle, empty tunnel shows red one cycle after the request and green two cycles after it.
- R3: At most one end holds the grant at any time, so the two greens are never on together.
- R4: The tunnel is granted only in a cycle where the tunnel count is zero. An end that waits while the other end's cars are still inside stays red until the last of them has exited.
- R5: When both ends request in the same cycle, the grant goes to the end not served last. The first such tie after reset goes to the island.
- R6: A green end admits a waiting car first. Once that car has cleared the stop line, the end turns red if the opposite end is waiting, and the waiting end is then granted.
- R7: The tunnel count rises by one for each car admitted at either end. It falls by one for each exit pulse and never drops below zero: an exit pulse into an empty tunnel leaves it empty and grantable.
- R8: The island count rises on each island-side exit pulse, falls for each island car admitted, and never exceeds `ISLE_CAP`.
- R9: The mainland is not granted while the island count equals `ISLE_CAP`. A mainland green ends once the island count plus the tunnel count reaches `ISLE_CAP`.
- R10: Each light controller cycles through four states: red (light red) goes to green on a grant. Green goes to entering when a car waits. Entering returns to green or goes to exiting when the car clears. Exiting (light red) returns to red and releases the grant when the tunnel is empty. Green and entering drive the green light; red and exiting drive the red light.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| isl_entry | input | 1 | High while a car waits at the island stop line |
| isl_exit | input | 1 | Pulse: a car leaves the tunnel onto the island |
| main_entry | input | 1 | High while a car waits at the mainland stop line |
| main_exit | input | 1 | Pulse: a car leaves the tunnel onto the mainland |
| isl_green | output | 1 | Island green light |
| isl_red | output | 1 | Island red light |
| main_green | output | 1 | Mainland green light |
| main_red | output | 1 | Mainland red light |

## Verification
The bench holds the waiting end's sensor high while the other end's car is still in the tunnel. A design that granted without an empty tunnel would light the waiting end early, while a design that never cleared its grant would keep it red forever. An exit pulse into an empty tunnel is sent to catch a counter that wraps below zero; such a counter would block every later grant. A simultaneous-request case checks alternation, where a fixed priority would serve the same end twice. Filling the island to capacity checks that a full island keeps the mainland red until an island car leaves, and that the mainland green drops at the limit instead of letting one car too many in.

// File: rtl/tc_pkg.sv
// Shared types for the tunnel controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package tc_pkg;

    // Per-end light controller state.
    typedef enum logic [1:0] {
        LT_RED   = 2'd0,
        LT_GREEN = 2'd1,
        LT_ENTER = 2'd2,
        LT_EXIT  = 2'd3
    } lt_state_t;

    // Which end currently holds the tunnel.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_ISL  = 2'd1,
        OWN_MAIN = 2'd2
    } owner_t;

endpackage

// File: rtl/tc_occ_counter.sv
// Saturating up/down occupancy counter.
// Counts one on inc, minus one on dec, holds when both or neither are set.
// Never goes below zero and never above MAX.
// Assumes: at most one event of each kind per cycle.
module tc_occ_counter #(
    parameter int MAX = 15,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = W'(MAX);

    // Update the count with floor and ceiling saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !dec && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/tc_light_fsm.sv
// Four-state light controller for one tunnel end.
// Requests the tunnel while a car waits and the light is red.
// Admits waiting cars while green, and yields when asked after at least one
// admission. Stops at once on the capacity stop. Releases the grant once the
// tunnel has drained.
// Assumes: car_wait is a level that drops once the car has driven in.
module tc_light_fsm
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic car_wait,
    input  logic grant,
    input  logic yield_req,
    input  logic stop,
    input  logic tun_empty,
    output logic green,
    output logic red,
    output logic req,
    output logic use_tun,
    output logic rel,
    output logic admit
);

    lt_state_t state, state_nx;

    // Next-state choice for the light sequence.
    always_comb begin
        state_nx = state;
        case (state)
            LT_RED: begin
                if (grant) state_nx = LT_GREEN;
            end
            LT_GREEN: begin
                if (stop)           state_nx = LT_EXIT;
                else if (car_wait)  state_nx = LT_ENTER;
                else if (yield_req) state_nx = LT_EXIT;
            end
            LT_ENTER: begin
                if (!car_wait) state_nx = (yield_req || stop) ? LT_EXIT : LT_GREEN;
            end
            LT_EXIT: begin
                if (tun_empty) state_nx = LT_RED;
            end
            default: state_nx = LT_RED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LT_RED;
        else        state <= state_nx;
    end

    // Handshake and light outputs decoded from state.
    always_comb begin
        green   = (state == LT_GREEN) || (state == LT_ENTER);
        red     = !green;
        req     = (state == LT_RED) && car_wait;
        use_tun = (state != LT_RED);
        rel     = (state == LT_EXIT) && tun_empty;
        admit   = (state == LT_GREEN) && car_wait && !stop;
    end

endmodule

// File: rtl/tc_arbiter.sv
// Tunnel arbiter: hands the tunnel to one end at a time.
// Grants only into an empty tunnel, alternates on ties, and asks the holder
// to yield while the other end waits.
// Assumes: rel pulses come only from the current holder.
module tc_arbiter
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_isl,
    input  logic req_main,
    input  logic use_isl,
    input  logic use_main,
    input  logic rel_isl,
    input  logic rel_main,
    input  logic tun_empty,
    input  logic main_ok,
    output logic grant_isl,
    output logic grant_main,
    output logic yield_isl,
    output logic yield_main
);

    owner_t owner;
    logic   last_isl;
    logic   main_can;

    assign main_can = req_main && main_ok;

    // Ownership and last-served tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= OWN_NONE;
            last_isl <= 1'b0;
        end else begin
            case (owner)
                OWN_NONE: begin
                    if (tun_empty) begin
                        if (req_isl && (!main_can || !last_isl)) begin
                            owner    <= OWN_ISL;
                            last_isl <= 1'b1;
                        end else if (main_can) begin
                            owner    <= OWN_MAIN;
                            last_isl <= 1'b0;
                        end
                    end
                end
                OWN_ISL:  if (rel_isl)  owner <= OWN_NONE;
                OWN_MAIN: if (rel_main) owner <= OWN_NONE;
                default:  owner <= OWN_NONE;
            endcase
        end
    end

    // Grant and yield decode.
    always_comb begin
        grant_isl  = (owner == OWN_ISL);
        grant_main = (owner == OWN_MAIN);
        yield_isl  = grant_isl  && use_isl  && req_main;
        yield_main = grant_main && use_main && req_isl;
    end

endmodule

// File: rtl/tunnel_ctrl.sv
// One-lane tunnel traffic controller top.
// Two light controllers, one arbiter and two occupancy counters.
// The mainland end is stopped when the island plus the tunnel reach ISLE_CAP.
// Assumes: entry sensors are levels, exit sensors are single-cycle pulses.
module tunnel_ctrl #(
    parameter int ISLE_CAP = 8,
    parameter int TUN_MAX  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic isl_entry,
    input  logic isl_exit,
    input  logic main_entry,
    input  logic main_exit,
    output logic isl_green,
    output logic isl_red,
    output logic main_green,
    output logic main_red
);

    localparam int TCW = $clog2(TUN_MAX + 1);
    localparam int ICW = $clog2(ISLE_CAP + 1);
    localparam int SW  = ((TCW > ICW) ? TCW : ICW) + 1;

    logic [TCW-1:0] tun_cnt;
    logic [ICW-1:0] isl_cnt;
    logic tun_empty, main_ok, main_stop;
    logic tun_inc, tun_dec;
    logic req_isl, req_main, use_isl, use_main, rel_isl, rel_main;
    logic admit_isl, admit_main;
    logic grant_isl, grant_main, yield_isl, yield_main;

    // Capacity and emptiness conditions from the counters.
    always_comb begin
        tun_empty = (tun_cnt == '0);
        main_ok   = (isl_cnt < ICW'(ISLE_CAP));
        main_stop = (SW'(isl_cnt) + SW'(tun_cnt)) >= SW'(ISLE_CAP);
        tun_inc   = admit_isl || admit_main;
        tun_dec   = isl_exit || main_exit;
    end

    tc_light_fsm u_isl_lt (
        .clk      (clk),
        .rst_n    (rst_n),
        .car_wait (isl_entry),
        .grant    (grant_isl),
        .yield_req(yield_isl),
        .stop     (1'b0),
        .tun_empty(tun_empty),
        .green    (isl_green),
        .red      (isl_red),
        .req      (req_isl),
        .use_tun  (use_isl),
        .rel      (rel_isl),
        .admit    (admit_isl)
    );

    tc_light_fsm u_main_lt (
        .clk      (clk),
        .rst_n    (rst_n),
        .car_wait (main_entry),
        .grant    (grant_main),
        .yield_req(yield_main),
        .stop     (main_stop),
        .tun_empty(tun_empty),
        .green    (main_green),
        .red      (main_red),
        .req      (req_main),
        .use_tun  (use_main),
        .rel      (rel_main),
        .admit    (admit_main)
    );

    tc_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_isl   (req_isl),
        .req_main  (req_main),
        .use_isl   (use_isl),
        .use_main  (use_main),
        .rel_isl   (rel_isl),
        .rel_main  (rel_main),
        .tun_empty (tun_empty),
        .main_ok   (main_ok),
        .grant_isl (grant_isl),
        .grant_main(grant_main),
        .yield_isl (yield_isl),
        .yield_main(yield_main)
    );

    tc_occ_counter #(.MAX(TUN_MAX), .W(TCW)) u_tun_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tun_inc),
        .dec  (tun_dec),
        .cnt  (tun_cnt)
    );

    tc_occ_counter #(.MAX(ISLE_CAP), .W(ICW)) u_isl_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (isl_exit),
        .dec  (admit_isl),
        .cnt  (isl_cnt)
    );

endmodule

// File: rtl/tc_checker.sv
// Property checker for tunnel_ctrl, attached with bind below.
// Assumes: it observes the top's grant, light and counter signals.
module tc_checker #(
    parameter int ISLE_CAP = 8,
    parameter int TCW      = 4,
    parameter int ICW      = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           isl_green,
    input logic           main_green,
    input logic           grant_isl,
    input logic           grant_main,
    input logic [TCW-1:0] tun_cnt,
    input logic [ICW-1:0] isl_cnt,
    input logic           tun_inc,
    input logic           tun_dec
);

    // R2: a green light implies the grant for that end.
    assert_green_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (isl_green |-> grant_isl) and (main_green |-> grant_main));

    // R3: only one end owns the tunnel, never both greens.
    assert_one_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_isl, grant_main}) && !(isl_green && main_green));

    // R4: a new grant starts only from an empty tunnel.
    assert_grant_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_isl) || $rose(grant_main)) |-> ($past(tun_cnt) == '0));

    // R7: an exit into an empty tunnel keeps the count at zero.
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tun_cnt == '0 && tun_dec && !tun_inc) |=> (tun_cnt == '0));

    // R8: the island never holds more than its capacity.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        isl_cnt <= ICW'(ISLE_CAP));

    // R9: the mainland is granted only while the island has room.
    assert_cap_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_main) |-> ($past(isl_cnt) < ICW'(ISLE_CAP)));

endmodule

bind tunnel_ctrl tc_checker #(
    .ISLE_CAP(ISLE_CAP),
    .TCW     (TCW),
    .ICW     (ICW)
) i_tc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .isl_green (isl_green),
    .main_green(main_green),
    .grant_isl (grant_isl),
    .grant_main(grant_main),
    .tun_cnt   (tun_cnt),
    .isl_cnt   (isl_cnt),
    .tun_inc   (tun_inc),
    .tun_dec   (tun_dec)
);

// File: tb/test_tunnel_ctrl.sv
// Directed bench for tunnel_ctrl: one task per scenario.
module test_tunnel_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic isl_entry, isl_exit, main_entry, main_exit;
    logic isl_green, isl_red, main_green, main_red;
    int   checks = 0;
    int   errors = 0;

    tunnel_ctrl #(.ISLE_CAP(CAP), .TUN_MAX(15)) i_tunnel_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .isl_entry (isl_entry),
        .isl_exit  (isl_exit),
        .main_entry(main_entry),
        .main_exit (main_exit),
        .isl_green (isl_green),
        .isl_red   (isl_red),
        .main_green(main_green),
        .main_red  (main_red)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Exclusion is checked at every sample point the tasks use.
    task automatic chk_excl(input string req);
        chk(req, "both greens", isl_green && main_green, 1'b0);
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        isl_entry  = 1'b0;
        isl_exit   = 1'b0;
        main_entry = 1'b0;
        main_exit  = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_main_exit();
        main_exit = 1'b1;
        step(1);
        main_exit = 1'b0;
    endtask

    task automatic pulse_isl_exit();
        isl_exit = 1'b1;
        step(1);
        isl_exit = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n      = 1'b0;
        isl_entry  = 1'b1;
        main_entry = 1'b1;
        isl_exit   = 1'b0;
        main_exit  = 1'b0;
        step(2);
        chk("R1", "island red in reset", isl_red, 1'b1);
        chk("R1", "mainland red in reset", main_red, 1'b1);
        chk("R1", "island green in reset", isl_green, 1'b0);
        do_reset();
        chk("R1", "mainland green after reset", main_green, 1'b0);
    endtask

    // R2, R10: single island car into an idle tunnel.
    task automatic t_single();
        do_reset();
        isl_entry = 1'b1;
        step(1);
        chk("R2", "island red one cycle after request", isl_red, 1'b1);
        step(1);
        chk("R2", "island green two cycles after request", isl_green, 1'b1);
        chk("R3", "mainland red while island green", main_red, 1'b1);
        step(1);
        chk("R10", "green held in entering", isl_green, 1'b1);
        isl_entry = 1'b0;
        step(1);
        chk("R10", "back to green after car clears", isl_green, 1'b1);
        step(3);
        chk("R10", "green held with nobody waiting", isl_green, 1'b1);
        chk_excl("R3");
    endtask

    // R4, R6: mainland waits for the island car to leave the tunnel.
    task automatic t_empty();
        main_entry = 1'b1;
        step(1);
        chk("R6", "island yields to waiting mainland", isl_red, 1'b1);
        step(3);
        chk("R4", "mainland red while tunnel occupied", main_red, 1'b1);
        chk_excl("R3");
        pulse_main_exit();
        step(1);
        chk("R4", "mainland red during release", main_red, 1'b1);
        step(1);
        chk("R4", "mainland red on grant cycle", main_red, 1'b1);
        step(1);
        chk("R6", "mainland green after tunnel empties", main_green, 1'b1);
        chk("R3", "island red while mainland green", isl_red, 1'b1);
        main_entry = 1'b0;
    endtask

    // R7: exit into an empty tunnel must not wrap the count.
    task automatic t_floor();
        do_reset();
        pulse_main_exit();
        isl_entry = 1'b1;
        step(2);
        chk("R7", "grant still given after empty-tunnel exit", isl_green, 1'b1);
        isl_entry = 1'b0;
    endtask

    // R5: simultaneous requests alternate.
    task automatic t_tie();
        do_reset();
        isl_entry  = 1'b1;
        main_entry = 1'b1;
        step(2);
        chk("R5", "island wins first tie", isl_green, 1'b1);
        chk("R5", "mainland loses first tie", main_red, 1'b1);
        step(1);
        isl_entry = 1'b0;
        step(1);
        chk("R6", "island yields after one car", isl_red, 1'b1);
        isl_entry = 1'b1;
        pulse_main_exit();
        step(3);
        chk("R5", "mainland wins second tie", main_green, 1'b1);
        chk("R5", "island waits on second tie", isl_red, 1'b1);
        isl_entry  = 1'b0;
        main_entry = 1'b0;
    endtask

    // R8, R9: island capacity blocks the mainland.
    task automatic t_cap();
        do_reset();
        main_entry = 1'b1;
        step(2);
        chk("R9", "mainland green with room", main_green, 1'b1);
        step(1);
        main_entry = 1'b0;
        step(1);
        main_entry = 1'b1;
        step(1);
        main_entry = 1'b0;
        step(1);
        chk("R9", "mainland red once island plus tunnel reach limit", main_red, 1'b1);
        main_entry = 1'b1;
        pulse_isl_exit();
        pulse_isl_exit();
        step(5);
        chk("R9", "mainland held red with full island", main_red, 1'b1);
        chk("R8", "island red with no island car", isl_red, 1'b1);
        isl_entry = 1'b1;
        step(2);
        chk("R8", "island car granted from full island", isl_green, 1'b1);
        step(1);
        isl_entry = 1'b0;
        step(1);
        chk("R6", "island yields to mainland", isl_red, 1'b1);
        pulse_main_exit();
        step(3);
        chk("R9", "mainland granted once island has room", main_green, 1'b1);
        chk_excl("R3");
        main_entry = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_empty();
        t_floor();
        t_tie();
        t_cap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule